// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Protection Path

This block guards 32-bit memory words with a 7-bit check code that travels on an 8-bit side lane. The top bit of the lane is always driven low and is disregarded on the way back in. On the write side, a purely combinational encoder turns the outgoing word into its check byte. Each check bit is the parity of the data bits picked out by one row of the parity-check matrix.

On the read side, the returned word and check byte go in with a valid strobe. The block recomputes the code from the returned word and XORs it with the stored code to form the syndrome. It then sorts the access into one of three classes: clean, single-bit (correctable), or multi-bit (uncorrectable). For a data-bit error it inverts the failing bit. The corrected word, the class, the failing bit index and the syndrome are all registered, and they appear one clock after the strobe.

Every matrix column has odd weight, so any two-bit error gives a nonzero even-weight syndrome. No column can produce such a syndrome, which is why a two-bit error is never mistaken for a single one. A constant inversion pattern on the code places the word 32'h9ABCDEF0 on check byte 8'h11.

Top module: `ecc_secded_path`

## Requirements
- R1: `wr_check[6:0]` is, for each row, the parity of the data bits that row selects, XORed with a fixed pattern. `wr_check[7]` is always 0. A `wr_data` of 32'h9ABCDEF0 gives `wr_check` = 8'h11.
- R2: The registered `syndrome[6:0]` equals the code recomputed from `rd_data` XOR `rd_check[6:0]`. `syndrome[7]` is 0, and `rd_check[7]` has no effect on any output.
- R3: A zero syndrome gives `error_type` = 2'b00, `err_bit` = 0 and `out_data` equal to `rd_data`.
- R4: When the syndrome equals the column of data bit i, the block gives `error_type` = 2'b01, `err_bit` = i, and `out_data` equal to `rd_data` with bit i inverted. Reading 32'h9ABEDEF0 with check 8'h11 gives syndrome 8'h37, `err_bit` 17 and `out_data` 32'h9ABCDEF0.
- R5: When the syndrome equals the column of check bit j (a one-hot value 1<<j), the block gives `error_type` = 2'b01 and `err_bit` = 32+j, and `out_data` equals `rd_data`.
- R6: Any nonzero syndrome that matches no column gives `error_type` = 2'b10, `err_bit` = 0 and `out_data` equal to `rd_data`. This covers every two-bit error across the data and check bits. `error_type` never takes the value 2'b11.
- R7: `out_valid` is `rd_valid` delayed by one clock. The result registers load only on a cycle with `rd_valid` high and otherwise hold their value.
- R8: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_data`, `error_type`, `err_bit` and `syndrome` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 32 | Word about to be written |
| wr_check | output | 8 | Check byte for `wr_data` (combinational) |
| rd_valid | input | 1 | Read return strobe |
| rd_data | input | 32 | Word returned from memory |
| rd_check | input | 8 | Check byte returned from memory |
| out_valid | output | 1 | Registered result valid |
| out_data | output | 32 | Corrected (or passed-through) word |
| error_type | output | 2 | 00 clean, 01 single, 10 multi |
| err_bit | output | 6 | Failing bit: 0..31 data, 32..38 check |
| syndrome | output | 8 | Registered syndrome, bit 7 zero |

## Verification
The assertions watch the cycle-level contract on every cycle:
- the output strobe trails the input strobe by one clock;
- the class code stays legal;
- a clean result always carries a zero syndrome;
- a multi-bit or check-bit result returns the word untouched, while a data-bit result differs from the returned word in exactly one bit;
- the spare lane bit stays low.

Only the bench scenarios can show that the matrix itself is right. That covers the stated word-to-code pairing and the syndrome 37h at bit 17. It also covers the round trip, in which every one of the 39 single flips is located at its own index, and the pairs of flips that are all refused. The bench also shows that the unused lane bit changes nothing.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int DATA_W   = 32;
    localparam int CODE_W   = 7;
    localparam int LANE_W   = 8;
    localparam int IDX_W    = 6;
    localparam int COL_WT   = 3;
    localparam int PIN_IDX  = 17;
    localparam logic [CODE_W-1:0] PIN_COL = 7'h37;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'b00,
        ERR_SINGLE = 2'b01,
        ERR_MULTI  = 2'b10
    } err_kind_e;

    typedef struct packed {
        word_t           data;
        err_kind_e       kind;
        logic [IDX_W-1:0] bit_idx;
        code_t           syn;
    } rd_result_t;

    // Column of data bit idx: the idx-th odd (weight-3) 7-bit value in
    // ascending order, with one pinned weight-5 column.
    function automatic code_t hcol(input int idx);
        code_t c;
        int    k;
        c = '0;
        k = 0;
        if (idx == PIN_IDX) begin
            c = PIN_COL;
        end else begin
            for (int v = 0; v < (1 << CODE_W); v++) begin
                if ($countones(v[CODE_W-1:0]) == COL_WT) begin
                    if (k == idx) c = v[CODE_W-1:0];
                    k++;
                end
            end
        end
        return c;
    endfunction

    function automatic word_t row_sel(input int r);
        word_t m;
        code_t c;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c    = hcol(i);
            m[i] = c[r];
        end
        return m;
    endfunction

    function automatic code_t raw_parity(input word_t d);
        code_t p;
        p = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (d[i]) p = p ^ hcol(i);
        end
        return p;
    endfunction

    localparam word_t ANCHOR_WORD = 32'h9ABCDEF0;
    localparam code_t ANCHOR_CODE = 7'h11;
    localparam code_t CODE_FLIP   = raw_parity(ANCHOR_WORD) ^ ANCHOR_CODE;

endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
    import ecc_pkg::*;
(
    input  word_t data,
    output code_t code
);
    code_t par;

    generate
        for (genvar r = 0; r < CODE_W; r++) begin : g_row
            localparam word_t SEL = row_sel(r);
            assign par[r] = ^(data & SEL);
        end
    endgenerate

    assign code = par ^ CODE_FLIP;
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
    import ecc_pkg::*;
(
    input  code_t            syn,
    output word_t            flip,
    output err_kind_e        kind,
    output logic [IDX_W-1:0] bit_idx
);
    word_t              dhit;
    logic [CODE_W-1:0]  chit;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_dcol
            localparam code_t COL = hcol(i);
            assign dhit[i] = (syn == COL);
        end
        for (genvar j = 0; j < CODE_W; j++) begin : g_ccol
            localparam code_t COL = code_t'(1 << j);
            assign chit[j] = (syn == COL);
        end
    endgenerate

    assign flip = dhit;

    always_comb begin
        bit_idx = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (dhit[i]) bit_idx = IDX_W'(i);
        end
        for (int j = 0; j < CODE_W; j++) begin
            if (chit[j]) bit_idx = IDX_W'(DATA_W + j);
        end
        if (syn == '0) begin
            kind = ERR_NONE;
        end else if ((|dhit) || (|chit)) begin
            kind = ERR_SINGLE;
        end else begin
            kind    = ERR_MULTI;
            bit_idx = '0;
        end
    end
endmodule

// File: rtl/ecc_fix.sv
module ecc_fix
    import ecc_pkg::*;
(
    input  word_t raw,
    input  word_t flip,
    output word_t fixed
);
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign fixed[i] = flip[i] ? ~raw[i] : raw[i];
        end
    endgenerate
endmodule

// File: rtl/ecc_secded_path.sv
module ecc_secded_path
    import ecc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] wr_data,
    output logic [7:0]  wr_check,
    input  logic        rd_valid,
    input  logic [31:0] rd_data,
    input  logic [7:0]  rd_check,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic [1:0]  error_type,
    output logic [5:0]  err_bit,
    output logic [7:0]  syndrome
);
    localparam int PAD_W = LANE_W - CODE_W;

    code_t            wr_code;
    code_t            rd_code;
    code_t            syn_c;
    word_t            flip_c;
    word_t            fixed_c;
    err_kind_e        kind_c;
    logic [IDX_W-1:0] idx_c;
    rd_result_t       res_q;
    logic             vld_q;
    logic             unused_lane;

    assign unused_lane = rd_check[LANE_W-1];

    ecc_encode u_wenc (.data(wr_data), .code(wr_code));
    ecc_encode u_renc (.data(rd_data), .code(rd_code));

    assign syn_c = rd_code ^ rd_check[CODE_W-1:0];

    ecc_classify u_cls (
        .syn     (syn_c),
        .flip    (flip_c),
        .kind    (kind_c),
        .bit_idx (idx_c)
    );

    ecc_fix u_fix (.raw(rd_data), .flip(flip_c), .fixed(fixed_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '{data: '0, kind: ERR_NONE, bit_idx: '0, syn: '0};
        end else begin
            vld_q <= rd_valid;
            if (rd_valid) begin
                res_q <= '{data: fixed_c, kind: kind_c, bit_idx: idx_c, syn: syn_c};
            end
        end
    end

    assign wr_check   = {{PAD_W{1'b0}}, wr_code};
    assign out_valid  = vld_q;
    assign out_data   = res_q.data;
    assign error_type = res_q.kind;
    assign err_bit    = res_q.bit_idx;
    assign syndrome   = {{PAD_W{1'b0}}, res_q.syn};
endmodule

// File: rtl/ecc_secded_checker.sv
module ecc_secded_checker (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  wr_check,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic [1:0]  error_type,
    input logic [5:0]  err_bit,
    input logic [7:0]  syndrome
);
    assert_strobe_delay_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> out_valid);

    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> !out_valid);

    assert_legal_class_R6: assert property (@(posedge clk) disable iff (rst)
        error_type != 2'b11);

    assert_clean_zero_syn_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && error_type == 2'b00) |-> (syndrome == 8'h00 && err_bit == 6'd0));

    assert_multi_passthru_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && error_type == 2'b10) |-> (out_data == $past(rd_data)));

    assert_data_fix_one_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && error_type == 2'b01 && err_bit < 6'd32)
            |-> ($countones(out_data ^ $past(rd_data)) == 1));

    assert_check_err_passthru_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && error_type == 2'b01 && err_bit >= 6'd32)
            |-> (out_data == $past(rd_data)));

    always_comb begin
        assert_spare_lane_R1: assert (wr_check[7] == 1'b0);
    end
endmodule

bind ecc_secded_path ecc_secded_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_check   (wr_check),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .error_type (error_type),
    .err_bit    (err_bit),
    .syndrome   (syndrome)
);

// File: tb/tb_ecc_secded_path.sv
`timescale 1ns/1ps
module tb_ecc_secded_path;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] wr_data = '0;
    logic [7:0]  wr_check;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic [7:0]  rd_check = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [1:0]  error_type;
    logic [5:0]  err_bit;
    logic [7:0]  syndrome;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ecc_secded_path dut (.*);

    typedef struct packed {
        logic [31:0] data;
        logic [31:0] dflip;
        logic [6:0]  cflip;
        logic [1:0]  etype;
        logic [5:0]  ebit;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{32'h9ABCDEF0, 32'h00000000, 7'h00, 2'b00, 6'd0},
        '{32'h9ABCDEF0, 32'h00020000, 7'h00, 2'b01, 6'd17},
        '{32'h00000000, 32'h00000000, 7'h00, 2'b00, 6'd0},
        '{32'hFFFFFFFF, 32'h00000001, 7'h00, 2'b01, 6'd0},
        '{32'h12345678, 32'h80000000, 7'h00, 2'b01, 6'd31},
        '{32'hA5A5A5A5, 32'h00000000, 7'h04, 2'b01, 6'd34},
        '{32'hDEADBEEF, 32'h00000101, 7'h00, 2'b10, 6'd0},
        '{32'h0F0F0F0F, 32'h00000008, 7'h40, 2'b10, 6'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic encode(input logic [31:0] d, output logic [7:0] c);
        @(negedge clk);
        wr_data = d;
        #0.5;
        c = wr_check;
    endtask

    task automatic read_word(input logic [31:0] d, input logic [7:0] c);
        @(negedge clk);
        rd_data  = d;
        rd_check = c;
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic check_result(input string req, input logic [31:0] d, input logic [1:0] t,
                                input logic [5:0] b);
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk({req, " data"},  64'(out_data), 64'(d));
        chk({req, " type"},  64'(error_type), 64'(t));
        chk({req, " bit"},   64'(err_bit), 64'(b));
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  c;
        logic [31:0] rdw;
        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 valid", 64'(out_valid), 64'd0);
        chk("R8 data",  64'(out_data), 64'd0);
        chk("R8 type",  64'(error_type), 64'd0);
        chk("R8 bit",   64'(err_bit), 64'd0);
        chk("R8 syn",   64'(syndrome), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 post-reset valid", 64'(out_valid), 64'd0);

        // Vector table, encode through the write path then read back
        for (int k = 0; k < NV; k++) begin
            encode(VEC[k].data, c);
            rdw = VEC[k].data ^ VEC[k].dflip;
            read_word(rdw, {1'b0, c[6:0] ^ VEC[k].cflip});
            check_result($sformatf("R4/R5/R6 vec%0d", k),
                         (VEC[k].etype == 2'b10) ? rdw : VEC[k].data,
                         VEC[k].etype, VEC[k].ebit);
        end

        // R1: stated encoding
        encode(32'h9ABCDEF0, c);
        chk("R1 anchor code", 64'(c), 64'h11);

        // R4: stated correction with raw values, syndrome 37h
        read_word(32'h9ABEDEF0, 8'h11);
        check_result("R4 stated", 32'h9ABCDEF0, 2'b01, 6'd17);
        chk("R2 stated syndrome", 64'(syndrome), 64'h37);

        // R3: clean read, zero syndrome
        read_word(32'h9ABCDEF0, 8'h11);
        check_result("R3 clean", 32'h9ABCDEF0, 2'b00, 6'd0);
        chk("R3 syn", 64'(syndrome), 64'h0);

        // R2: spare lane bit ignored
        read_word(32'h9ABEDEF0, 8'h91);
        check_result("R2 lane7 ignored", 32'h9ABCDEF0, 2'b01, 6'd17);
        chk("R2 lane7 syndrome", 64'(syndrome), 64'h37);

        // R7: results hold while rd_valid low
        @(negedge clk);
        rd_data  = 32'h0;
        rd_check = 8'h7F;
        @(negedge clk);
        chk("R7 hold valid", 64'(out_valid), 64'd0);
        chk("R7 hold data", 64'(out_data), 64'h9ABCDEF0);
        chk("R7 hold syn", 64'(syndrome), 64'h37);

        // R4/R5: every single flip of one word located
        encode(32'h3C96A55A, c);
        for (int i = 0; i < 39; i++) begin
            if (i < 32) begin
                read_word(32'h3C96A55A ^ (32'd1 << i), c);
                check_result("R4 sweep", 32'h3C96A55A, 2'b01, 6'(i));
            end else begin
                read_word(32'h3C96A55A, c ^ (8'd1 << (i - 32)));
                check_result("R5 sweep", 32'h3C96A55A, 2'b01, 6'(i));
                chk("R2 check-bit syndrome", 64'(syndrome), 64'(8'd1 << (i - 32)));
            end
        end

        // R6: pairs of data flips are refused, data passed through
        encode(32'h5A5AC3C3, c);
        for (int i = 0; i < 31; i += 3) begin
            rdw = 32'h5A5AC3C3 ^ (32'd1 << i) ^ (32'd1 << (i + 1));
            read_word(rdw, c);
            check_result("R6 pair", rdw, 2'b10, 6'd0);
        end
        read_word(32'h5A5AC3C3, c ^ 8'h03);
        check_result("R6 check pair", 32'h5A5AC3C3, 2'b10, 6'd0);

        // R8: reset mid-run clears outputs
        read_word(32'h5A5AC3C3 ^ 32'h1, c);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 re-reset data", 64'(out_data), 64'd0);
        chk("R8 re-reset type", 64'(error_type), 64'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule